// File: doc/BRIEF.md
# ECC Event Interrupt Flag Unit

This unit gathers error events reported by three tightly coupled memory ports (one instruction port, data port 0 and data port 1) and one fault-capture source. It keeps them as sticky bits in a 32-bit flag register. Each port has three flags: a corrected single-bit error, a detected double-bit error, and an error-count expiry. The expiry flag comes from a per-port counter. The counter advances on every single-bit or double-bit error and is compared against an 8-bit threshold. The ECC decoders and address comparators sit outside the unit and deliver their results as one-cycle pulses.

Software reads the register at any time with no side effects and clears flags by writing ones. A write is refused while the software-reset synchroniser reports busy. The refused write answers with a bus error and leaves the flags untouched. One registered interrupt line combines the flags through a 32-bit enable mask.

The register port is plain and has no back-pressure. A write is taken in the cycle `wr_en` is high, and `bus_err` answers that write one cycle later. The event inputs are single-cycle pulses, and every pulse is accepted.

Top module: `ecc_irq_flags`

## Requirements
- R1: After reset the flag register reads 0x00000000, and both `irq` and `bus_err` are low.
- R2: A write clears each implemented flag whose data bit is 1 and leaves every flag whose data bit is 0 unchanged.
- R3: A write while `swrst_busy` is high changes no flag, does not restart any counter, and drives `bus_err` high in the following cycle. An accepted write leaves `bus_err` low.
- R4: The flag layout is as follows. Port p (0 = instruction, 1 = data 0, 2 = data 1) uses bit 8p for single-error-corrected, bit 8p+1 for double-error-detected and bit 8p+2 for count-expired. Bit 24 is fault capture. Every other bit reads 0 and ignores writes.
- R5: A pulse on `ev_sec[p]` or `ev_ded[p]` sets that port's matching flag, visible on `rd_data` in the next cycle. A pulse on `ev_fault` sets bit 24 in the same way.
- R6: When a hardware set and a software clear hit the same bit in one cycle, the bit ends up set.
- R7: Each port counts its single-bit and double-bit error cycles, at one per cycle even if both pulse together, and the count saturates at that port's threshold. The count-expired flag sets in the cycle after the count reaches the threshold. The count restarts from zero when software clears that port's count-expired flag through an accepted write. An error in the same cycle as that clear counts as the first of the new run.
- R8: A threshold of 0 keeps the port's count-expired flag from setting.
- R9: `irq` is registered. It equals the OR of (flags AND `irq_mask`) as they stood in the previous cycle.
- R10: `rd_data` always shows the current flags, and reading never alters them. A read after a clear shows the cleared state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| swrst_busy | input | 1 | Software-reset synchronisation in progress; writes are refused |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data, 1 = clear the flag |
| rd_data | output | 32 | Current flag register value |
| bus_err | output | 1 | Error response for the write of the previous cycle |
| ev_sec | input | 3 | Per-port single-bit corrected pulse |
| ev_ded | input | 3 | Per-port double-bit detected pulse |
| ev_fault | input | 1 | Fault capture pulse |
| thresh | input | 24 | Per-port error thresholds, port p in bits [8p+7:8p] |
| irq_mask | input | 32 | Interrupt enable per flag bit |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach is a collision between a count-expiry and a software clear. This happens when the clear of a count-expired flag lands in the same cycle as a new error on that port. It also happens when a set and a clear collide on one bit while the threshold is small enough for the counter to wrap quickly. Directed steps construct these collisions, including one during `swrst_busy`. Afterwards a seeded random phase keeps the thresholds between 0 and 4 and issues frequent clear writes, so the three-way overlaps of event, clear and busy recur many times. A bench model checks every cycle against the flags, the interrupt and the bus error.

// File: rtl/ecc_irq_pkg.sv
package ecc_irq_pkg;
  localparam int NUM_PORTS   = 3;
  localparam int CNT_W       = 8;
  localparam int REG_W       = 32;
  localparam int PORT_STRIDE = 8;
  localparam int SLOT_SEC    = 0;
  localparam int SLOT_DED    = 1;
  localparam int SLOT_EXP    = 2;
  localparam int FAULT_BIT   = 24;

  function automatic logic [REG_W-1:0] impl_bits(input int nports);
    logic [REG_W-1:0] m;
    m = '0;
    for (int p = 0; p < nports; p++) begin
      m[p*PORT_STRIDE + SLOT_SEC] = 1'b1;
      m[p*PORT_STRIDE + SLOT_DED] = 1'b1;
      m[p*PORT_STRIDE + SLOT_EXP] = 1'b1;
    end
    m[FAULT_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ecc_err_counter.sv
module ecc_err_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_evt,
  input  logic             restart,
  input  logic [CNT_W-1:0] thresh,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, base, cnt_d;
  logic             halted;

  always_comb begin
    base   = restart ? '0 : cnt_q;
    halted = (thresh == '0) || (base >= thresh);
    cnt_d  = base;
    expire = 1'b0;
    if (err_evt && !halted) begin
      cnt_d  = base + 1'b1;
      expire = (cnt_d == thresh);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_NO_EXPIRE_ZERO_THR: assert property (@(posedge clk) disable iff (!rst_n)
    (thresh == '0) |-> !expire); // R8
  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(thresh) && thresh != '0 && $past(cnt_q) <= $past(thresh)) |-> cnt_q <= thresh); // R7
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !err_evt) |=> cnt_q == '0); // R7
endmodule

// File: rtl/ecc_flag_reg.sv
module ecc_flag_reg #(
  parameter int                REG_W = 32,
  parameter logic [REG_W-1:0] IMPL  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             swrst_busy,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [REG_W-1:0] set_vec,
  output logic [REG_W-1:0] clr_vec,
  output logic [REG_W-1:0] flag_q,
  output logic             bus_err
);
  logic             wr_ok;
  logic [REG_W-1:0] flag_d;

  assign wr_ok   = wr_en && !swrst_busy;
  assign clr_vec = wr_ok ? (wr_data & IMPL) : '0;

  always_comb flag_d = ((flag_q & ~clr_vec) | set_vec) & IMPL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= '0;
      bus_err <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      bus_err <= wr_en && swrst_busy;
    end
  end

  AST_BUSY_WRITE_ERRS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && swrst_busy) |=> bus_err); // R3
  AST_BUSY_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && swrst_busy && set_vec == '0) |=> flag_q == $past(flag_q)); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> (flag_q & $past(set_vec)) == $past(set_vec)); // R6
  AST_ZERO_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && set_vec == '0) |=> (flag_q & ~$past(wr_data)) == ($past(flag_q) & ~$past(wr_data))); // R2
endmodule

// File: rtl/ecc_irq_gen.sv
module ecc_irq_gen #(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] flags,
  input  logic [REG_W-1:0] mask,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(flags & mask);
  end

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flags) == '0) |-> !irq); // R9
endmodule

// File: rtl/ecc_irq_flags.sv
module ecc_irq_flags
  import ecc_irq_pkg::*;
#(
  parameter int NPORT = NUM_PORTS,
  parameter int CW    = CNT_W,
  parameter int RW    = REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swrst_busy,
  input  logic              wr_en,
  input  logic [RW-1:0]     wr_data,
  output logic [RW-1:0]     rd_data,
  output logic              bus_err,
  input  logic [NPORT-1:0]  ev_sec,
  input  logic [NPORT-1:0]  ev_ded,
  input  logic              ev_fault,
  input  logic [NPORT*CW-1:0] thresh,
  input  logic [RW-1:0]     irq_mask,
  output logic              irq
);
  localparam logic [RW-1:0] IMPL = impl_bits(NPORT);

  logic [NPORT-1:0] expire;
  logic [RW-1:0]    set_vec, clr_vec, flag_q;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    ecc_err_counter #(.CNT_W(CW)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .err_evt (ev_sec[p] | ev_ded[p]),
      .restart (clr_vec[p*PORT_STRIDE + SLOT_EXP]),
      .thresh  (thresh[p*CW +: CW]),
      .expire  (expire[p])
    );
  end

  always_comb begin
    set_vec = '0;
    for (int p = 0; p < NPORT; p++) begin
      set_vec[p*PORT_STRIDE + SLOT_SEC] = ev_sec[p];
      set_vec[p*PORT_STRIDE + SLOT_DED] = ev_ded[p];
      set_vec[p*PORT_STRIDE + SLOT_EXP] = expire[p];
    end
    set_vec[FAULT_BIT] = ev_fault;
  end

  ecc_flag_reg #(.REG_W(RW), .IMPL(IMPL)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .swrst_busy (swrst_busy),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .set_vec    (set_vec),
    .clr_vec    (clr_vec),
    .flag_q     (flag_q),
    .bus_err    (bus_err)
  );

  ecc_irq_gen #(.REG_W(RW)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .flags (flag_q),
    .mask  (irq_mask),
    .irq   (irq)
  );

  assign rd_data = flag_q;

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~IMPL) == '0); // R4
  AST_FAULT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> rd_data[FAULT_BIT]); // R5
endmodule

// File: tb/ecc_irq_flags_test.sv
`timescale 1ns/1ps
module ecc_irq_flags_test;
  logic        clk = 0, rst_n = 0, swrst_busy = 0, wr_en = 0, ev_fault = 0, irq, bus_err;
  logic [31:0] wr_data = 0, rd_data, irq_mask = 0;
  logic [2:0]  ev_sec = 0, ev_ded = 0;
  logic [23:0] thresh = 0;

  int n_tests = 0, n_fail = 0;
  logic [31:0] mf;
  logic [7:0]  mc [3];
  logic        mirq, mberr;

  always #2.5 clk = ~clk;

  ecc_irq_flags uut (.clk(clk), .rst_n(rst_n), .swrst_busy(swrst_busy), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .bus_err(bus_err), .ev_sec(ev_sec), .ev_ded(ev_ded),
    .ev_fault(ev_fault), .thresh(thresh), .irq_mask(irq_mask), .irq(irq));

  function automatic logic [31:0] impl_mask();
    return 32'h0107_0707;
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 0; wr_data = 0; ev_sec = 0; ev_ded = 0; ev_fault = 0; swrst_busy = 0;
  endtask

  task automatic cyc();
    logic [31:0] clr, set;
    logic [7:0]  nc [3];
    logic [7:0]  base, thr;
    logic        nirq, nberr;
    clr = (wr_en && !swrst_busy) ? (wr_data & impl_mask()) : 32'h0;
    set = 0;
    for (int p = 0; p < 3; p++) begin
      thr  = thresh[p*8 +: 8];
      base = clr[p*8+2] ? 8'd0 : mc[p];
      if ((ev_sec[p] | ev_ded[p]) && thr != 0 && base < thr) begin
        base = base + 8'd1;
        if (base == thr) set[p*8+2] = 1'b1;
      end
      nc[p] = base;
      set[p*8]   = ev_sec[p];
      set[p*8+1] = ev_ded[p];
    end
    set[24] = ev_fault;
    nirq  = |(mf & irq_mask);
    nberr = wr_en && swrst_busy;
    @(posedge clk); #1;
    mf = (mf & ~clr) | set;
    for (int p = 0; p < 3; p++) mc[p] = nc[p];
    mirq = nirq; mberr = nberr;
    check(rd_data == mf, "R2 R4 R5 R6 R7 R10 flags", rd_data, mf);
    check(irq == mirq, "R9 irq", {31'd0, irq}, {31'd0, mirq});
    check(bus_err == mberr, "R3 bus_err", {31'd0, bus_err}, {31'd0, mberr});
  endtask

  task automatic wr(input logic [31:0] d, input logic busy);
    wr_en = 1; wr_data = d; swrst_busy = busy;
    cyc();
    idle_inputs();
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] snap;
    void'($urandom(32'd20240611));
    mf = 0; mirq = 0; mberr = 0;
    for (int p = 0; p < 3; p++) mc[p] = 0;
    #12;
    check(rd_data == 0, "R1 reset flags", rd_data, 0);
    check(irq == 0 && bus_err == 0, "R1 reset irq/bus_err", {30'd0, irq, bus_err}, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;

    // thresholds: port0 = 2, port1 = 0, port2 = 3
    thresh = {8'd3, 8'd0, 8'd2};
    irq_mask = 32'hFFFF_FFFF;
    ev_sec = 3'b001; cyc(); idle_inputs();
    check(rd_data[0] && !rd_data[2], "R5 port0 single-error flag", rd_data, 32'h1);
    cyc();
    check(irq == 1, "R9 irq one cycle after flag", {31'd0, irq}, 1);
    ev_ded = 3'b001; cyc(); idle_inputs();
    check(rd_data[2], "R7 port0 count reached threshold 2", rd_data, 32'h7);
    // clear expiry, counter restarts: two more errors needed
    wr(32'h0000_0004, 0);
    check(!rd_data[2], "R10 read after clear shows cleared", rd_data, 32'h3);
    ev_sec = 3'b001; cyc(); idle_inputs();
    check(!rd_data[2], "R7 one error after restart", rd_data, 32'h3);
    ev_sec = 3'b001; cyc(); idle_inputs();
    check(rd_data[2], "R7 second error after restart", rd_data, 32'h7);
    // threshold zero on port1
    for (int i = 0; i < 5; i++) begin ev_ded = 3'b010; cyc(); end
    idle_inputs();
    check(rd_data[9] && !rd_data[10], "R8 zero threshold no expiry", rd_data, mf);
    // write zeros: nothing changes
    snap = rd_data;
    wr(32'h0, 0);
    check(rd_data == snap, "R2 write of zeros", rd_data, snap);
    wr(32'h0000_0001, 0);
    check(rd_data == (snap & ~32'h1), "R2 clear bit 0", rd_data, snap & ~32'h1);
    // set wins
    wr_en = 1; wr_data = 32'h0001_0000; ev_sec = 3'b100; cyc(); idle_inputs();
    check(rd_data[16], "R6 set wins over clear", rd_data, mf);
    // busy write
    snap = rd_data;
    wr(32'hFFFF_FFFF, 1);
    check(rd_data == snap && bus_err, "R3 busy write refused", rd_data, snap);
    cyc();
    check(!bus_err, "R3 bus_err only one cycle", {31'd0, bus_err}, 0);
    // reserved bits and fault
    wr(32'hFFFF_FFFF, 0);
    check(rd_data == 0, "R4 clear all implemented, reserved read zero", rd_data, 0);
    ev_fault = 1; cyc(); idle_inputs();
    check(rd_data == 32'h0100_0000, "R5 fault capture bit 24", rd_data, 32'h0100_0000);
    // mask
    irq_mask = 32'h0; cyc(); cyc();
    check(!irq, "R9 masked flags no irq", {31'd0, irq}, 0);
    snap = rd_data; cyc();
    check(rd_data == snap, "R10 reads have no side effect", rd_data, snap);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0)
        thresh = {8'($urandom_range(0, 4)), 8'($urandom_range(0, 4)), 8'($urandom_range(0, 4))};
      irq_mask   = ($urandom_range(0, 3) == 0) ? $urandom : 32'hFFFF_FFFF;
      ev_sec     = 3'($urandom) & 3'($urandom);
      ev_ded     = 3'($urandom) & 3'($urandom) & 3'($urandom);
      ev_fault   = ($urandom_range(0, 15) == 0);
      wr_en      = ($urandom_range(0, 3) == 0);
      wr_data    = $urandom_range(0, 1) ? $urandom : (32'h0000_0004 << (8 * $urandom_range(0, 2)));
      swrst_busy = ($urandom_range(0, 7) == 0);
      cyc();
    end
    idle_inputs();
    cyc();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule